// File: doc/BRIEF.md
# Cartridge Work-RAM Select Decoder

This block sits on a cartridge board and produces the enable lines for an 8 KiB work RAM that answers CPU addresses $6000-$7FFF, together with the two ROM enable lines. It watches the CPU phase-2 clock, the host's active-low ROM-area select (which the host derives from phase-2 and A15), address bits A14 and A13, the read/write line and a write-protect switch. It runs from a fast sampling clock. The asynchronous bus inputs are synchronized first, and the RAM chip enable is then decoded from them.

The host's ROM-area select rises late, up to 33 ns after phase-2 rises. During a store to the mapper registers at $E000-$FFFF, the bus therefore briefly looks like a work-RAM access. To stop that false window from reaching the RAM, the phase-2 copy used for the RAM decode has its rising edge delayed by a parameterised number of sampling cycles. A decode that lasts only a moment is rejected. Any enable that is emitted is held for at least a minimum strobe width. The ROM lines and the RAM write and output enables are simple combinational functions of the bus.

Top module: `wram_sel_dec`

## Requirements
- R1: `ram_ce_n` goes low only after the synchronized phase-2, `romsel_n`, `addr_a14` and `addr_a13` have all been high together; with any one of them low for a whole phase-2 cycle, `ram_ce_n` stays high.
- R2: The rising edge of phase-2 is delayed by DELAY_CYC = ceil(LAG_PS / CLK_PS) sampling cycles (7 by default) before it can enable the RAM. After all inputs of a valid access go high together, `ram_ce_n` first reads low SYNC_STAGES + DELAY_CYC + GLITCH_CYC cycles later (11 by default). A `romsel_n` that falls fewer than DELAY_CYC cycles after phase-2 rises produces no RAM enable.
- R3: A decode that holds for fewer than GLITCH_CYC consecutive synchronized cycles (2 by default) produces no RAM enable.
- R4: Outside reset, every low pulse on `ram_ce_n` lasts at least MIN_CYC = ceil(MIN_STROBE_PS / CLK_PS) cycles (10 by default). A decode that is accepted but then ends early yields a pulse of exactly MIN_CYC cycles.
- R5: Once `ram_ce_n` has been low for MIN_CYC cycles, it returns high one cycle after the synchronized decode drops. For a phase-2 fall, that is SYNC_STAGES + 1 cycles after the input edge.
- R6: `rom_ce_n` equals `romsel_n` combinationally.
- R7: `rom_oe_n` is the inverse of `cpu_rw` (1 = read), so the ROM output is off during CPU writes.
- R8: `ram_we_n` is 1 while `wr_protect` is 1; otherwise it equals `cpu_rw`.
- R9: `ram_oe_n` is always 0.
- R10: While `rst` is 1, `ram_ce_n` is 1 whatever the bus does, and phase-2 is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Active-high reset; phase-2 treated as low |
| cpu_m2 | input | 1 | CPU phase-2 clock (asynchronous) |
| romsel_n | input | 1 | Host ROM-area select, active low, late vs. phase-2 |
| addr_a14 | input | 1 | CPU address bit 14 |
| addr_a13 | input | 1 | CPU address bit 13 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| wr_protect | input | 1 | 1 blocks RAM writes |
| ram_ce_n | output | 1 | Work-RAM chip enable, active low |
| ram_we_n | output | 1 | Work-RAM write enable, active low |
| ram_oe_n | output | 1 | Work-RAM output enable, active low |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |

## Verification
The assertions assume that the bus inputs change no faster than the sampling clock can see them, and that reset is held at time zero. They also assume that a phase-2 high phase is long compared with DELAY_CYC + GLITCH_CYC + MIN_CYC, so a genuine access can always finish its minimum strobe before phase-2 falls. The stimulus changes inputs only on falling sampling edges. It keeps every genuine phase-2 high phase at 56 cycles, about one CPU half-period. Late selects, short address pulses and reset are applied only within those limits.

// File: rtl/wram_dec_pkg.sv
package wram_dec_pkg;

  // Bus inputs that need synchronizing before the RAM decode.
  typedef struct packed {
    logic m2;
    logic romsel_n;
    logic a14;
    logic a13;
  } bus_in_t;

  // Round a time span up to whole sampling cycles.
  function automatic int unsigned ps_to_cycles(input int unsigned span_ps,
                                               input int unsigned clk_ps);
    return (span_ps + clk_ps - 1) / clk_ps;
  endfunction

  // Bits needed to hold the values 0..maxv (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/wram_sync.sv
module wram_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/wram_m2_delay.sv
module wram_m2_delay #(
  parameter int unsigned DEPTH = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic m2_s,
  output logic m2_late
);

  generate
    if (DEPTH == 0) begin : g_none
      assign m2_late = m2_s;
    end else begin : g_line
      logic [DEPTH-1:0] line_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          line_q <= '0;
        end else begin
          line_q[0] <= m2_s;
          for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
      end
      assign m2_late = line_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/wram_sel_filter.sv
module wram_sel_filter
  import wram_dec_pkg::*;
#(
  parameter int unsigned GLITCH_CYC = 2,
  parameter int unsigned MIN_CYC    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic sel
);

  localparam int unsigned GW = cnt_bits(GLITCH_CYC);
  localparam int unsigned HW = cnt_bits(MIN_CYC);
  localparam logic [GW-1:0] RUN_MAX  = GW'(GLITCH_CYC - 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(MIN_CYC - 1);

  logic [GW-1:0] run_q;
  logic [HW-1:0] hold_q;
  logic          accept;
  logic          may_release;

  // Current cycle plus run_q earlier ones reach the glitch threshold.
  assign accept      = hit && (run_q >= RUN_MAX);
  assign may_release = (hold_q >= HOLD_MAX);

  always_ff @(posedge clk) begin
    if (rst || !hit)          run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !sel)            hold_q <= '0;
    else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         sel <= 1'b0;
    else if (!sel)                   sel <= accept;
    else if (!hit && may_release)    sel <= 1'b0;
  end

endmodule

// File: rtl/wram_sel_dec.sv
module wram_sel_dec
  import wram_dec_pkg::*;
#(
  parameter int unsigned CLK_PS        = 5000,
  parameter int unsigned LAG_PS        = 33000,
  parameter int unsigned MIN_STROBE_PS = 50000,
  parameter int unsigned GLITCH_CYC    = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_m2,
  input  logic romsel_n,
  input  logic addr_a14,
  input  logic addr_a13,
  input  logic cpu_rw,
  input  logic wr_protect,
  output logic ram_ce_n,
  output logic ram_we_n,
  output logic ram_oe_n,
  output logic rom_ce_n,
  output logic rom_oe_n
);

  localparam int unsigned DELAY_CYC = ps_to_cycles(LAG_PS, CLK_PS);
  localparam int unsigned MIN_CYC   = ps_to_cycles(MIN_STROBE_PS, CLK_PS);

  bus_in_t bus_raw;
  bus_in_t bus_s;

  // Named internal events used by the checker.
  logic m2_sync;
  logic m2_late;
  logic m2_qual;
  logic dec_hit;
  logic sel_q;

  // Reset forces phase-2 low, like a pulldown on a floating line.
  always_comb begin
    bus_raw.m2       = cpu_m2 & ~rst;
    bus_raw.romsel_n = romsel_n;
    bus_raw.a14      = addr_a14;
    bus_raw.a13      = addr_a13;
  end

  wram_sync #(
    .WIDTH ($bits(bus_in_t)),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (bus_raw),
    .q  (bus_s)
  );

  assign m2_sync = bus_s.m2;

  wram_m2_delay #(
    .DEPTH(DELAY_CYC)
  ) u_dly (
    .clk    (clk),
    .rst    (rst),
    .m2_s   (m2_sync),
    .m2_late(m2_late)
  );

  // The rising edge is delayed; the falling edge follows the synced line.
  assign m2_qual = m2_late & m2_sync;
  assign dec_hit = m2_qual & bus_s.romsel_n & bus_s.a14 & bus_s.a13;

  wram_sel_filter #(
    .GLITCH_CYC(GLITCH_CYC),
    .MIN_CYC   (MIN_CYC)
  ) u_filt (
    .clk(clk),
    .rst(rst),
    .hit(dec_hit),
    .sel(sel_q)
  );

  assign ram_ce_n = ~(sel_q & ~rst);
  assign ram_we_n = wr_protect | cpu_rw;
  assign ram_oe_n = 1'b0;
  assign rom_ce_n = romsel_n;
  assign rom_oe_n = ~cpu_rw;

endmodule

// File: rtl/wram_sel_dec_chk.sv
module wram_sel_dec_chk
  import wram_dec_pkg::*;
#(
  parameter int unsigned CLK_PS        = 5000,
  parameter int unsigned MIN_STROBE_PS = 50000,
  parameter int unsigned GLITCH_CYC    = 2
) (
  input logic clk,
  input logic rst,
  input logic ram_ce_n,
  input logic m2_late,
  input logic dec_hit
);

  localparam int unsigned MIN_CYC = ps_to_cycles(MIN_STROBE_PS, CLK_PS);

  logic [15:0] lo_run;
  logic [15:0] hit_run;

  always_ff @(posedge clk) begin
    if (rst || ram_ce_n)    lo_run <= '0;
    else if (lo_run != '1)  lo_run <= lo_run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !dec_hit)    hit_run <= '0;
    else if (hit_run != '1) hit_run <= hit_run + 1'b1;
  end

  // R1
  ce_needs_decode_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_ce_n) |-> $past(dec_hit));

  // R2
  ce_after_late_m2_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_ce_n) |-> $past(m2_late));

  // R3
  glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_ce_n) |-> (hit_run >= 16'(GLITCH_CYC)));

  // R4
  min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_ce_n) |-> (lo_run >= 16'(MIN_CYC)));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && !dec_hit && (lo_run >= 16'(MIN_CYC - 1))) |=> ram_ce_n);

  // R10
  reset_block_chk: assert property (@(posedge clk)
    rst |-> ram_ce_n);

endmodule

bind wram_sel_dec wram_sel_dec_chk #(
  .CLK_PS       (CLK_PS),
  .MIN_STROBE_PS(MIN_STROBE_PS),
  .GLITCH_CYC   (GLITCH_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ram_ce_n(ram_ce_n),
  .m2_late (m2_late),
  .dec_hit (dec_hit)
);

// File: tb/wram_sel_dec_bench.sv
`timescale 1ns/1ps
module wram_sel_dec_bench;

  localparam int CLK_PS = 5000;
  localparam int SYNC   = 2;
  localparam int GLITCH = 2;
  // Restated from the requirements: round up lag and strobe to cycles.
  localparam int DLY    = (33000 + CLK_PS - 1) / CLK_PS;
  localparam int MINW   = (50000 + CLK_PS - 1) / CLK_PS;
  localparam int M2_HI  = 56;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_m2 = 1'b0, romsel_n = 1'b1, addr_a14 = 1'b0, addr_a13 = 1'b0;
  logic cpu_rw = 1'b1, wr_protect = 1'b0;
  logic ram_ce_n, ram_we_n, ram_oe_n, rom_ce_n, rom_oe_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wram_sel_dec u_wram_sel_dec (
    .clk(clk), .rst(rst), .cpu_m2(cpu_m2), .romsel_n(romsel_n),
    .addr_a14(addr_a14), .addr_a13(addr_a13), .cpu_rw(cpu_rw),
    .wr_protect(wr_protect), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
  );

  // Pulse monitor on ram_ce_n, sampled on falling edges.
  int lo_len = 0, pulses = 0, last_w = 0, min_w = 1000000;
  always @(negedge clk) begin
    if (rst) lo_len = 0;
    else if (!ram_ce_n) lo_len++;
    else if (lo_len > 0) begin
      pulses++;
      last_w = lo_len;
      if (lo_len < min_w) min_w = lo_len;
      lo_len = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_idle();
    cpu_m2 = 0; romsel_n = 1; addr_a14 = 0; addr_a13 = 0; cpu_rw = 1;
  endtask

  task automatic t_reset_state();
    cyc(4);
    chk(ram_ce_n == 1, "R10 ce in reset", ram_ce_n, 1);
    chk(ram_oe_n == 0, "R9 oe low", ram_oe_n, 0);
    chk(rom_oe_n == 0, "R7 rom oe on read", rom_oe_n, 0);
    rst = 0;
    cyc(4);
  endtask

  task automatic t_ram_access(input logic rw);
    int first_lo = -1, first_hi = -1, p0 = pulses;
    cpu_rw = rw; addr_a14 = 1; addr_a13 = 1; romsel_n = 1; cpu_m2 = 1;
    for (int i = 1; i <= M2_HI; i++) begin
      @(negedge clk);
      if (!ram_ce_n && first_lo < 0) first_lo = i;
      if (i == 3 && rw == 0) chk(ram_we_n == 0, "R8 we follows rw", ram_we_n, 0);
    end
    chk(first_lo == SYNC + DLY + GLITCH, "R2 enable latency", first_lo, SYNC + DLY + GLITCH);
    cpu_m2 = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (ram_ce_n && first_hi < 0) first_hi = i;
    end
    chk(first_hi == SYNC + 1, "R5 release after m2 fall", first_hi, SYNC + 1);
    chk(pulses == p0 + 1, "R1 one enable per access", pulses - p0, 1);
    bus_idle();
    cyc(10);
  endtask

  task automatic t_race_e000();
    int p0 = pulses;
    cpu_rw = 0; addr_a14 = 1; addr_a13 = 1; romsel_n = 1; cpu_m2 = 1;
    cyc(DLY - 1);
    romsel_n = 0;
    cyc(M2_HI - DLY + 1);
    cpu_m2 = 0;
    cyc(DLY - 1);
    romsel_n = 1;
    cyc(20);
    chk(pulses == p0, "R2 late select gives no enable", pulses - p0, 0);
    bus_idle();
    cyc(5);
  endtask

  task automatic t_addr_pulse(input int width, input int exp_pulses, input string req);
    int p0 = pulses;
    cpu_m2 = 1; romsel_n = 1; addr_a14 = 1; addr_a13 = 0;
    cyc(20);
    addr_a13 = 1;
    cyc(width);
    addr_a13 = 0;
    cyc(30);
    cpu_m2 = 0;
    cyc(10);
    chk(pulses - p0 == exp_pulses, req, pulses - p0, exp_pulses);
    if (exp_pulses > 0) chk(last_w == MINW, "R4 stretched width", last_w, MINW);
    bus_idle();
    cyc(5);
  endtask

  task automatic t_miss(input logic a14, input logic a13, input logic rs, input string req);
    int p0 = pulses;
    addr_a14 = a14; addr_a13 = a13; romsel_n = rs; cpu_m2 = 1;
    cyc(M2_HI);
    cpu_m2 = 0; romsel_n = 1;
    cyc(10);
    chk(pulses == p0, req, pulses - p0, 0);
    bus_idle();
    cyc(5);
  endtask

  task automatic t_static_lines();
    cpu_rw = 0; wr_protect = 1; #1;
    chk(ram_we_n == 1, "R8 protect blocks write", ram_we_n, 1);
    wr_protect = 0; #1;
    chk(ram_we_n == 0, "R8 write passes", ram_we_n, 0);
    chk(rom_oe_n == 1, "R7 rom oe off on write", rom_oe_n, 1);
    cpu_rw = 1; #1;
    chk(ram_we_n == 1, "R8 read keeps we high", ram_we_n, 1);
    chk(rom_oe_n == 0, "R7 rom oe on read", rom_oe_n, 0);
    romsel_n = 0; #1;
    chk(rom_ce_n == 0, "R6 rom ce low", rom_ce_n, 0);
    romsel_n = 1; #1;
    chk(rom_ce_n == 1, "R6 rom ce high", rom_ce_n, 1);
    chk(ram_oe_n == 0, "R9 oe stays low", ram_oe_n, 0);
    cyc(2);
  endtask

  task automatic t_reset_mid();
    int lows = 0;
    addr_a14 = 1; addr_a13 = 1; romsel_n = 1; cpu_m2 = 1;
    cyc(SYNC + DLY + GLITCH + 3);
    chk(ram_ce_n == 0, "R1 enable before reset", ram_ce_n, 0);
    rst = 1; #1;
    chk(ram_ce_n == 1, "R10 reset drops enable", ram_ce_n, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!ram_ce_n) lows++;
    end
    chk(lows == 0, "R10 held off in reset", lows, 0);
    bus_idle();
    cyc(10);
    rst = 0;
    cyc(10);
  endtask

  initial begin
    bus_idle();
    t_reset_state();
    t_ram_access(1'b1);
    t_ram_access(1'b0);
    t_race_e000();
    t_addr_pulse(1, 0, "R3 short decode rejected");
    t_addr_pulse(4, 1, "R3 accepted short decode");
    t_miss(1'b0, 1'b1, 1'b1, "R1 a14 low no enable");
    t_miss(1'b1, 1'b0, 1'b1, "R1 a13 low no enable");
    t_miss(1'b1, 1'b1, 1'b0, "R1 romsel low no enable");
    t_static_lines();
    t_reset_mid();
    chk(min_w >= MINW, "R4 narrowest pulse", min_w, MINW);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule